// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must move so that dependent instructions see correct operands without software padding. It compares the source register numbers of the instruction in execute with the destinations of the older instructions in the memory and writeback stages. From that comparison it selects a forwarding source for each execute operand.

It also detects a load in execute whose result the instruction in decode needs at once. In that case it holds fetch and decode and sends a bubble into execute. While a multi-cycle multiplier reports busy, it freezes fetch, decode and execute and feeds bubbles into memory. When execute reports a mispredicted branch, it flushes the two younger stages so that fetch can be redirected, and this flush overrides every stall.

All control outputs are pure functions of the current inputs. The clock and reset drive only the property checks embedded in the logic.

Top module: `hz_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (mem_reg_write=1), its destination is not x0, and that destination equals an execute source, the select for that operand is 2'b10 (take the memory-stage ALU result).
- R2: When only the writeback-stage instruction writes a non-x0 destination equal to an execute source, the select for that operand is 2'b01 (take the writeback result).
- R3: When the memory and writeback destinations both match the same source, the select is 2'b10, so the memory stage wins.
- R4: A select stays 2'b00 (register file value) when the only matching destination is x0 or the matching producer has its write flag low.
- R5: The two operand selects are computed independently, so each follows only its own source register.
- R6: A load in execute (ex_is_load=1, ex_reg_write=1, destination not x0) whose destination matches a source that the decode instruction reads causes a load-use stall. During that stall stall_fetch=1, stall_decode=1, flush_execute=1, and stall_execute, flush_decode and flush_memory are all 0.
- R7: No load-use stall is raised in any of these cases: the decode instruction does not read the matching operand, the load's destination is x0, the execute instruction is not a load, or it does not write a register.
- R8: While mul_busy=1 and no misprediction is present, stall_fetch, stall_decode, stall_execute and flush_memory are 1, and flush_decode and flush_execute are 0, even if a load-use match also exists.
- R9: When ex_mispredict=1, flush_decode=1 and flush_execute=1, and all three stalls and flush_memory are 0, whatever the load-use and busy conditions are.
- R10: With no hazard present, including straight after reset, every stall and flush output is 0 and both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded property checks |
| rst | input | 1 | Synchronous active-high reset; disables the property checks |
| dec_rs1 | input | 5 | First source register of the instruction in decode |
| dec_rs2 | input | 5 | Second source register of the instruction in decode |
| dec_uses_rs1 | input | 1 | Decode instruction reads its first source |
| dec_uses_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register of the instruction in memory |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register of the instruction in writeback |
| wb_reg_write | input | 1 | Writeback instruction writes a register |
| mul_busy | input | 1 | Multi-cycle multiplier is still working |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| stall_fetch | output | 1 | Hold the fetch register (program counter) |
| stall_decode | output | 1 | Hold the fetch-to-decode register |
| stall_execute | output | 1 | Hold the decode-to-execute register |
| flush_decode | output | 1 | Clear the fetch-to-decode register |
| flush_execute | output | 1 | Clear the decode-to-execute register (bubble) |
| flush_memory | output | 1 | Clear the execute-to-memory register (bubble) |

## Verification
Every select, stall and flush is combinational, so each result belongs to the same cycle as the stage contents that cause it, before the edge that would load the pipeline registers. The bench therefore applies each constructed stage pattern just after a falling edge and reads the outputs a quarter period later, well before the next rising edge. It never waits for or counts rising edges to find a result. Each scenario task sets up the whole stage picture at once, so no output can carry over from an earlier pattern.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_addr_t;

    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic      wr;
        reg_addr_t rd;
    } producer_t;

    typedef struct packed {
        logic stall_fetch;
        logic stall_decode;
        logic stall_execute;
        logic flush_decode;
        logic flush_execute;
        logic flush_memory;
    } pipe_ctrl_t;

    localparam reg_addr_t ZERO_REG = '0;

    function automatic logic dep_hit(reg_addr_t src, producer_t p);
        return p.wr && (p.rd != ZERO_REG) && (src == p.rd);
    endfunction

endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_addr_t src,
    input  producer_t mem_p,
    input  producer_t wb_p,
    output fwd_sel_e  sel
);

    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem = dep_hit(src, mem_p);
        hit_wb  = dep_hit(src, wb_p);
        if (hit_mem)
            sel = FWD_MEM;
        else if (hit_wb)
            sel = FWD_WB;
        else
            sel = FWD_NONE;
    end

    AST_FWD_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        (src == ZERO_REG) |-> (sel == FWD_NONE)); // R4

    AST_FWD_MEM_WINS: assert property (@(posedge clk) disable iff (rst)
        (mem_p.wr && wb_p.wr && mem_p.rd == src && wb_p.rd == src && src != ZERO_REG)
            |-> (sel == FWD_MEM)); // R3

    AST_FWD_NO_WRITERS: assert property (@(posedge clk) disable iff (rst)
        (!mem_p.wr && !wb_p.wr) |-> (sel == FWD_NONE)); // R4

    AST_FWD_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R5

endmodule

// File: rtl/hz_load_use_detect.sv
module hz_load_use_detect
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_addr_t dec_rs1,
    input  reg_addr_t dec_rs2,
    input  logic      dec_uses_rs1,
    input  logic      dec_uses_rs2,
    input  producer_t ex_p,
    input  logic      ex_is_load,
    output logic      lu_hit
);

    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a  = dec_uses_rs1 && dep_hit(dec_rs1, ex_p);
        hit_b  = dec_uses_rs2 && dep_hit(dec_rs2, ex_p);
        lu_hit = ex_is_load && (hit_a || hit_b);
    end

    AST_LU_ONLY_LOADS: assert property (@(posedge clk) disable iff (rst)
        lu_hit |-> (ex_is_load && ex_p.wr)); // R7

    AST_LU_NOT_X0: assert property (@(posedge clk) disable iff (rst)
        (ex_p.rd == ZERO_REG) |-> !lu_hit); // R7

    AST_LU_NEEDS_READER: assert property (@(posedge clk) disable iff (rst)
        (!dec_uses_rs1 && !dec_uses_rs2) |-> !lu_hit); // R7

endmodule

// File: rtl/hz_stall_flush_ctrl.sv
module hz_stall_flush_ctrl
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lu_hit,
    input  logic       mul_busy,
    input  logic       mispredict,
    output pipe_ctrl_t ctrl
);

    always_comb begin
        ctrl = '0;
        if (mispredict) begin
            ctrl.flush_decode  = 1'b1;
            ctrl.flush_execute = 1'b1;
        end else if (mul_busy) begin
            ctrl.stall_fetch   = 1'b1;
            ctrl.stall_decode  = 1'b1;
            ctrl.stall_execute = 1'b1;
            ctrl.flush_memory  = 1'b1;
        end else if (lu_hit) begin
            ctrl.stall_fetch   = 1'b1;
            ctrl.stall_decode  = 1'b1;
            ctrl.flush_execute = 1'b1;
        end
    end

    AST_FLUSH_BEATS_STALL: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> (!ctrl.stall_fetch && !ctrl.stall_decode && !ctrl.stall_execute)); // R9

    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (mul_busy && !mispredict) |-> (ctrl.stall_execute && ctrl.flush_memory && !ctrl.flush_execute)); // R8

    AST_LU_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (lu_hit && !mul_busy && !mispredict) |-> (ctrl.stall_decode && ctrl.flush_execute)); // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!lu_hit && !mul_busy && !mispredict) |-> (ctrl == '0)); // R10

    AST_STALL_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.stall_fetch == ctrl.stall_decode)); // R6

endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   dec_rs1,
    input  logic [REG_AW-1:0]   dec_rs2,
    input  logic                dec_uses_rs1,
    input  logic                dec_uses_rs2,
    input  logic [REG_AW-1:0]   ex_rs1,
    input  logic [REG_AW-1:0]   ex_rs2,
    input  logic [REG_AW-1:0]   ex_rd,
    input  logic                ex_reg_write,
    input  logic                ex_is_load,
    input  logic [REG_AW-1:0]   mem_rd,
    input  logic                mem_reg_write,
    input  logic [REG_AW-1:0]   wb_rd,
    input  logic                wb_reg_write,
    input  logic                mul_busy,
    input  logic                ex_mispredict,
    output logic [1:0]          fwd_a_sel,
    output logic [1:0]          fwd_b_sel,
    output logic                stall_fetch,
    output logic                stall_decode,
    output logic                stall_execute,
    output logic                flush_decode,
    output logic                flush_execute,
    output logic                flush_memory
);

    localparam int N_OPS = 2;

    producer_t  ex_p;
    producer_t  mem_p;
    producer_t  wb_p;
    reg_addr_t  ex_src [N_OPS];
    fwd_sel_e   op_sel [N_OPS];
    logic       lu_hit;
    pipe_ctrl_t ctrl;

    assign ex_p   = '{wr: ex_reg_write,  rd: ex_rd};
    assign mem_p  = '{wr: mem_reg_write, rd: mem_rd};
    assign wb_p   = '{wr: wb_reg_write,  rd: wb_rd};
    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_fwd_select u_sel (
            .clk   (clk),
            .rst   (rst),
            .src   (ex_src[g]),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .sel   (op_sel[g])
        );
    end

    hz_load_use_detect u_lu (
        .clk          (clk),
        .rst          (rst),
        .dec_rs1      (dec_rs1),
        .dec_rs2      (dec_rs2),
        .dec_uses_rs1 (dec_uses_rs1),
        .dec_uses_rs2 (dec_uses_rs2),
        .ex_p         (ex_p),
        .ex_is_load   (ex_is_load),
        .lu_hit       (lu_hit)
    );

    hz_stall_flush_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lu_hit     (lu_hit),
        .mul_busy   (mul_busy),
        .mispredict (ex_mispredict),
        .ctrl       (ctrl)
    );

    assign fwd_a_sel     = op_sel[0];
    assign fwd_b_sel     = op_sel[1];
    assign stall_fetch   = ctrl.stall_fetch;
    assign stall_decode  = ctrl.stall_decode;
    assign stall_execute = ctrl.stall_execute;
    assign flush_decode  = ctrl.flush_decode;
    assign flush_execute = ctrl.flush_execute;
    assign flush_memory  = ctrl.flush_memory;

    AST_REDIRECT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
        ex_mispredict |-> (flush_decode && flush_execute && !flush_memory)); // R9

    AST_BUSY_HOLDS_FRONT: assert property (@(posedge clk) disable iff (rst)
        (mul_busy && !ex_mispredict) |-> (stall_fetch && stall_decode && !flush_decode)); // R8

endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       dec_uses_rs1, dec_uses_rs2, ex_reg_write, ex_is_load;
    logic       mem_reg_write, wb_reg_write, mul_busy, ex_mispredict;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       stall_fetch, stall_decode, stall_execute;
    logic       flush_decode, flush_execute, flush_memory;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hz_unit dut_i (
        .clk(clk), .rst(rst),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_uses_rs1(dec_uses_rs1), .dec_uses_rs2(dec_uses_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_reg_write(ex_reg_write), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
        .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .mul_busy(mul_busy), .ex_mispredict(ex_mispredict),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall_fetch(stall_fetch), .stall_decode(stall_decode),
        .stall_execute(stall_execute), .flush_decode(flush_decode),
        .flush_execute(flush_execute), .flush_memory(flush_memory)
    );

    // control vector order: stall_fetch, stall_decode, stall_execute,
    // flush_decode, flush_execute, flush_memory
    function automatic logic [5:0] ctrl_vec();
        return {stall_fetch, stall_decode, stall_execute,
                flush_decode, flush_execute, flush_memory};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_rs1 = 0; dec_rs2 = 0; dec_uses_rs1 = 0; dec_uses_rs2 = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_reg_write = 0; ex_is_load = 0;
        mem_rd = 0; mem_reg_write = 0; wb_rd = 0; wb_reg_write = 0;
        mul_busy = 0; ex_mispredict = 0;
    endtask

    // apply after a falling edge, sample a quarter period later
    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        idle();
        settle();
        check("R10 idle controls", {2'b0, ctrl_vec()}, 8'h00);
        check("R10 idle selects", {4'b0, fwd_a_sel, fwd_b_sel}, 8'h00);
    endtask

    task automatic t_mem_fwd();
        idle(); ex_rs1 = 5; ex_rs2 = 6; mem_rd = 5; mem_reg_write = 1;
        settle();
        check("R1 mem fwd A", {6'b0, fwd_a_sel}, 8'd2);
        check("R5 B unaffected", {6'b0, fwd_b_sel}, 8'd0);
        ex_rs1 = 9; ex_rs2 = 5;
        settle();
        check("R1 mem fwd B", {6'b0, fwd_b_sel}, 8'd2);
        check("R5 A unaffected", {6'b0, fwd_a_sel}, 8'd0);
        check("R10 fwd causes no stall", {2'b0, ctrl_vec()}, 8'h00);
    endtask

    task automatic t_wb_fwd();
        idle(); ex_rs1 = 3; ex_rs2 = 7; wb_rd = 7; wb_reg_write = 1;
        mem_rd = 4; mem_reg_write = 1;
        settle();
        check("R2 wb fwd B", {6'b0, fwd_b_sel}, 8'd1);
        check("R5 A unmatched", {6'b0, fwd_a_sel}, 8'd0);
        ex_rs1 = 4;
        settle();
        check("R5 A mem B wb", {4'b0, fwd_a_sel, fwd_b_sel}, 8'b0000_1001);
    endtask

    task automatic t_priority();
        idle(); ex_rs1 = 12; ex_rs2 = 12;
        mem_rd = 12; mem_reg_write = 1; wb_rd = 12; wb_reg_write = 1;
        settle();
        check("R3 mem over wb A", {6'b0, fwd_a_sel}, 8'd2);
        check("R3 mem over wb B", {6'b0, fwd_b_sel}, 8'd2);
        mem_reg_write = 0;
        settle();
        check("R3 wb when mem not writing", {6'b0, fwd_a_sel}, 8'd1);
    endtask

    task automatic t_x0();
        idle(); ex_rs1 = 0; ex_rs2 = 0;
        mem_rd = 0; mem_reg_write = 1; wb_rd = 0; wb_reg_write = 1;
        settle();
        check("R4 x0 no fwd", {4'b0, fwd_a_sel, fwd_b_sel}, 8'h00);
        idle(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; wb_rd = 6;
        settle();
        check("R4 no-write producer", {4'b0, fwd_a_sel, fwd_b_sel}, 8'h00);
    endtask

    task automatic t_load_use();
        idle(); ex_is_load = 1; ex_reg_write = 1; ex_rd = 9;
        dec_rs1 = 9; dec_uses_rs1 = 1;
        settle();
        check("R6 load-use rs1", {2'b0, ctrl_vec()}, 8'b0011_0010);
        dec_rs1 = 2; dec_rs2 = 9; dec_uses_rs2 = 1;
        settle();
        check("R6 load-use rs2", {2'b0, ctrl_vec()}, 8'b0011_0010);
    endtask

    task automatic t_no_load_use();
        idle(); ex_is_load = 1; ex_reg_write = 1; ex_rd = 9;
        dec_rs1 = 9; dec_uses_rs1 = 0;
        settle();
        check("R7 operand not read", {2'b0, ctrl_vec()}, 8'h00);
        ex_rd = 0; dec_rs1 = 0; dec_uses_rs1 = 1;
        settle();
        check("R7 load to x0", {2'b0, ctrl_vec()}, 8'h00);
        ex_rd = 9; dec_rs1 = 9; ex_is_load = 0;
        settle();
        check("R7 not a load", {2'b0, ctrl_vec()}, 8'h00);
        ex_is_load = 1; ex_reg_write = 0;
        settle();
        check("R7 load without write", {2'b0, ctrl_vec()}, 8'h00);
    endtask

    task automatic t_busy();
        idle(); mul_busy = 1;
        settle();
        check("R8 busy freeze", {2'b0, ctrl_vec()}, 8'b0011_1001);
        ex_is_load = 1; ex_reg_write = 1; ex_rd = 4; dec_rs2 = 4; dec_uses_rs2 = 1;
        settle();
        check("R8 busy over load-use", {2'b0, ctrl_vec()}, 8'b0011_1001);
        mul_busy = 0;
        settle();
        check("R6 load-use after busy", {2'b0, ctrl_vec()}, 8'b0011_0010);
    endtask

    task automatic t_mispredict();
        idle(); ex_mispredict = 1;
        settle();
        check("R9 flush alone", {2'b0, ctrl_vec()}, 8'b0000_0110);
        ex_is_load = 1; ex_reg_write = 1; ex_rd = 8; dec_rs1 = 8; dec_uses_rs1 = 1;
        settle();
        check("R9 flush over load-use", {2'b0, ctrl_vec()}, 8'b0000_0110);
        mul_busy = 1;
        settle();
        check("R9 flush over busy", {2'b0, ctrl_vec()}, 8'b0000_0110);
        idle();
        settle();
        check("R10 quiet after flush", {2'b0, ctrl_vec()}, 8'h00);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_x0();
        t_load_use();
        t_no_load_use();
        t_busy();
        t_mispredict();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule